// File: doc/BRIEF.md
# Test Port Instruction Decoder and Data Register Selector

This block is the instruction side of a boundary-scan test port. A separate state sequencer steps through the standard controller states and hands this block one strobe per state of interest. From those strobes the block shifts and latches a 4-bit instruction, decodes it, and routes the matching data register between the serial input `tdi` and the serial output `tdo`. The routing choices are a one-bit bypass stage, a 32-bit identification register, or an external boundary register that is reached through the `bsr*` pins.

The decoded instruction also drives the pin-control lines of the external boundary register. Three lines choose where its update stage goes: to the package pins, to the core inputs, or nowhere, with the outputs forced to high impedance. Three more lines gate its capture, shift and update clocks. The identification value is assembled from parameters: a version, a part number and a manufacturer code. Under the user-code instruction, the register instead captures a 32-bit word supplied by the system.

Top module: `tapsel_top`

## Requirements
- R1: At the Capture-IR strobe the instruction shift stage loads binary 0001. During Shift-IR it shifts from `tdi` toward `tdo` with the least significant bit first. The first four bits seen on `tdo` are therefore 1, 0, 0, 0.
- R2: The active instruction changes only on the Update-IR strobe. Reset and the Test-Logic-Reset strobe both set it to IDCODE (0010), or to BYPASS when the block is built without an identification register. After reset, a data scan reads the identification value.
- R3: BYPASS (1111) and every unassigned code place one stage between `tdi` and `tdo`. That stage loads 0 at Capture-DR, so the scan output is a 0 followed by the input delayed by one shift.
- R4: IDCODE (0010) selects the 32-bit identification register. Its bits 31..28 hold the version, 27..12 the part number, 11..1 the manufacturer code, and bit 0 is 1. It is shifted out least significant bit first.
- R5: USERCODE (0011) selects the identification register, which loads `userCode` at Capture-DR.
- R6: EXTEST (0000) selects the boundary register path, so `tdo` follows `bsrTdo`, and raises `pinFromBsr`.
- R7: INTEST (0100) selects the boundary register path and raises `coreFromBsr` only.
- R8: SAMPLE/PRELOAD (0001) selects the boundary register path and leaves `pinFromBsr`, `coreFromBsr` and `pinHighZ` low.
- R9: CLAMP (0101) raises `pinFromBsr` and keeps the bypass stage as the serial path, with no boundary strobes.
- R10: HIGHZ (0110) raises `pinHighZ` only and uses the bypass stage as the serial path.
- R11: `bsrCapture`, `bsrShift` and `bsrUpdate` follow the Capture-DR, Shift-DR and Update-DR strobes only while EXTEST, INTEST or SAMPLE/PRELOAD is active. They are low at all other times.
- R12: `tdo` and `tdoEn` change on the falling edge of `tck`. `tdoEn` is high only after a falling edge in the Shift-IR or Shift-DR state.
- R13: A low `trstN` resets the instruction and output enable at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tlResetSt | input | 1 | Controller is in Test-Logic-Reset |
| capIrSt | input | 1 | Controller is in Capture-IR |
| shiftIrSt | input | 1 | Controller is in Shift-IR |
| updIrSt | input | 1 | Controller is in Update-IR |
| capDrSt | input | 1 | Controller is in Capture-DR |
| shiftDrSt | input | 1 | Controller is in Shift-DR |
| updDrSt | input | 1 | Controller is in Update-DR |
| tdi | input | 1 | Serial test data in |
| userCode | input | 32 | User-programmed code captured under USERCODE |
| bsrTdo | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial test data out |
| tdoEn | output | 1 | Output enable for `tdo` |
| pinFromBsr | output | 1 | Drive package pins from the boundary update stage |
| coreFromBsr | output | 1 | Drive core inputs from the boundary update stage |
| pinHighZ | output | 1 | Force all outputs to high impedance |
| bsrCapture | output | 1 | Boundary register capture strobe |
| bsrShift | output | 1 | Boundary register shift strobe |
| bsrUpdate | output | 1 | Boundary register update strobe |

## Verification
The bench loads each public instruction and checks the pin-control lines just before Update-IR. A design that acted on the instruction while it was still shifting would change the pins too early and fail that check. The bench reads the identification and user codes bit by bit and looks for the one-cycle delay through the bypass stage. A design with a reversed shift direction, a wrong capture value, or a TDO that is off by one cycle gives a different bit stream. An unassigned opcode, CLAMP and HIGHZ must all leave the boundary strobes idle. A reset asserted between clock edges must clear EXTEST at once, which exposes a reset that is only synchronous.

// File: rtl/tapsel_pkg.sv
package tapsel_pkg;
  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] OP_EXTEST   = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 4'b0001;
  localparam logic [IR_W-1:0] OP_IDCODE   = 4'b0010;
  localparam logic [IR_W-1:0] OP_USERCODE = 4'b0011;
  localparam logic [IR_W-1:0] OP_INTEST   = 4'b0100;
  localparam logic [IR_W-1:0] OP_CLAMP    = 4'b0101;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 4'b0110;
  localparam logic [IR_W-1:0] OP_BYPASS   = 4'b1111;

  typedef enum logic [1:0] {
    PATH_BYPASS = 2'd0,
    PATH_ID     = 2'd1,
    PATH_BSR    = 2'd2
  } path_e;

  // Strobes handed from the control side to the datapath
  typedef struct packed {
    logic  captureDr;
    logic  shiftDr;
    logic  shiftIr;
    logic  loadUser;
    logic  irSerial;
    path_e path;
  } drCtl_t;
endpackage

// File: rtl/tapsel_ctrl.sv
module tapsel_ctrl
  import tapsel_pkg::*;
#(
  parameter bit HAS_ID = 1'b1
) (
  input  logic   tck,
  input  logic   trstN,
  input  logic   tlResetSt,
  input  logic   capIrSt,
  input  logic   shiftIrSt,
  input  logic   updIrSt,
  input  logic   capDrSt,
  input  logic   shiftDrSt,
  input  logic   updDrSt,
  input  logic   tdi,
  output drCtl_t drCtl,
  output logic   pinFromBsr,
  output logic   coreFromBsr,
  output logic   pinHighZ,
  output logic   bsrCapture,
  output logic   bsrShift,
  output logic   bsrUpdate
);
  localparam logic [IR_W-1:0] RESET_OP  = HAS_ID ? OP_IDCODE : OP_BYPASS;
  localparam logic [IR_W-1:0] CAPT_WORD = {{(IR_W-2){1'b0}}, 2'b01};

  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irActive;
  path_e           pathSel;
  logic            userSel;
  logic            bsrSel;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift  <= CAPT_WORD;
      irActive <= RESET_OP;
    end else begin
      if (tlResetSt)    irActive <= RESET_OP;
      else if (updIrSt) irActive <= irShift;

      if (capIrSt)        irShift <= CAPT_WORD;
      else if (shiftIrSt) irShift <= {tdi, irShift[IR_W-1:1]};
    end
  end

  always_comb begin
    pathSel     = PATH_BYPASS;
    userSel     = 1'b0;
    pinFromBsr  = 1'b0;
    coreFromBsr = 1'b0;
    pinHighZ    = 1'b0;
    case (irActive)
      OP_EXTEST: begin pathSel = PATH_BSR; pinFromBsr = 1'b1; end
      OP_INTEST: begin pathSel = PATH_BSR; coreFromBsr = 1'b1; end
      OP_SAMPLE: pathSel = PATH_BSR;
      OP_IDCODE: if (HAS_ID) pathSel = PATH_ID;
      OP_USERCODE: if (HAS_ID) begin pathSel = PATH_ID; userSel = 1'b1; end
      OP_CLAMP: pinFromBsr = 1'b1;
      OP_HIGHZ: pinHighZ = 1'b1;
      default: pathSel = PATH_BYPASS;
    endcase
  end

  assign bsrSel     = (pathSel == PATH_BSR);
  assign bsrCapture = bsrSel & capDrSt;
  assign bsrShift   = bsrSel & shiftDrSt;
  assign bsrUpdate  = bsrSel & updDrSt;

  assign drCtl.captureDr = capDrSt;
  assign drCtl.shiftDr   = shiftDrSt;
  assign drCtl.shiftIr   = shiftIrSt;
  assign drCtl.loadUser  = userSel;
  assign drCtl.irSerial  = irShift[0];
  assign drCtl.path      = pathSel;

  // R2: instruction only moves on Update-IR or Test-Logic-Reset
  a_r2_instr_hold: assert property (@(posedge tck) disable iff (!trstN)
    (!updIrSt && !tlResetSt) |=> $stable(irActive));
  // R1: capture loads the fixed 01 pattern into the shift stage
  a_r1_ir_capture: assert property (@(posedge tck) disable iff (!trstN)
    capIrSt |=> (irShift[1:0] == 2'b01));
  // R10: high impedance never coexists with a drive-from-boundary mode
  a_r10_highz_excl: assert property (@(posedge tck) disable iff (!trstN)
    pinHighZ |-> (!pinFromBsr && !coreFromBsr));
  // R11: boundary strobes never overlap
  a_r11_strobe_excl: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({bsrCapture, bsrShift, bsrUpdate}));
endmodule

// File: rtl/tapsel_data.sv
module tapsel_data
  import tapsel_pkg::*;
#(
  parameter int          ID_W     = 32,
  parameter logic [31:0] ID_VALUE = 32'h0000_0001
) (
  input  logic            tck,
  input  logic            trstN,
  input  drCtl_t          drCtl,
  input  logic            tdi,
  input  logic [ID_W-1:0] userCode,
  input  logic            bsrTdo,
  output logic            tdo,
  output logic            tdoEn
);
  logic            bypassReg;
  logic [ID_W-1:0] idReg;
  logic            drSerial;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bypassReg <= 1'b0;
      idReg     <= ID_VALUE[ID_W-1:0];
    end else if (drCtl.captureDr) begin
      bypassReg <= 1'b0;
      if (drCtl.path == PATH_ID)
        idReg <= drCtl.loadUser ? userCode : ID_VALUE[ID_W-1:0];
    end else if (drCtl.shiftDr) begin
      bypassReg <= tdi;
      if (drCtl.path == PATH_ID) idReg <= {tdi, idReg[ID_W-1:1]};
    end
  end

  always_comb begin
    case (drCtl.path)
      PATH_ID:  drSerial = idReg[0];
      PATH_BSR: drSerial = bsrTdo;
      default:  drSerial = bypassReg;
    endcase
  end

  // Output stage retimed to the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= drCtl.shiftIr ? drCtl.irSerial : drSerial;
      tdoEn <= drCtl.shiftIr | drCtl.shiftDr;
    end
  end

  // R3: bypass stage holds 0 right after capture
  a_r3_bypass_zero: assert property (@(posedge tck) disable iff (!trstN)
    drCtl.captureDr |=> (bypassReg == 1'b0));
  // R4: the identification value always ends in a 1
  a_r4_id_marker: assert property (@(posedge tck) disable iff (!trstN)
    (drCtl.captureDr && drCtl.path == PATH_ID && !drCtl.loadUser) |=> idReg[0]);
  // R12: output enable only seen in a shift state
  a_r12_tdo_enable: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (drCtl.shiftIr || drCtl.shiftDr));
endmodule

// File: rtl/tapsel_top.sv
module tapsel_top
  import tapsel_pkg::*;
#(
  parameter bit          HAS_ID  = 1'b1,
  parameter int          VER_W   = 4,
  parameter int          PART_W  = 16,
  parameter int          MFR_W   = 11,
  parameter logic [3:0]  ID_VER  = 4'h3,
  parameter logic [15:0] ID_PART = 16'hA5C1,
  parameter logic [10:0] ID_MFR  = 11'h2B5
) (
  input  logic        tck,
  input  logic        trstN,
  input  logic        tlResetSt,
  input  logic        capIrSt,
  input  logic        shiftIrSt,
  input  logic        updIrSt,
  input  logic        capDrSt,
  input  logic        shiftDrSt,
  input  logic        updDrSt,
  input  logic        tdi,
  input  logic [31:0] userCode,
  input  logic        bsrTdo,
  output logic        tdo,
  output logic        tdoEn,
  output logic        pinFromBsr,
  output logic        coreFromBsr,
  output logic        pinHighZ,
  output logic        bsrCapture,
  output logic        bsrShift,
  output logic        bsrUpdate
);
  localparam int ID_W = VER_W + PART_W + MFR_W + 1;
  localparam logic [ID_W-1:0] ID_VALUE =
    {ID_VER[VER_W-1:0], ID_PART[PART_W-1:0], ID_MFR[MFR_W-1:0], 1'b1};

  drCtl_t drCtl;

  tapsel_ctrl #(.HAS_ID(HAS_ID)) u_ctrl (
    .tck(tck), .trstN(trstN), .tlResetSt(tlResetSt),
    .capIrSt(capIrSt), .shiftIrSt(shiftIrSt), .updIrSt(updIrSt),
    .capDrSt(capDrSt), .shiftDrSt(shiftDrSt), .updDrSt(updDrSt),
    .tdi(tdi), .drCtl(drCtl),
    .pinFromBsr(pinFromBsr), .coreFromBsr(coreFromBsr), .pinHighZ(pinHighZ),
    .bsrCapture(bsrCapture), .bsrShift(bsrShift), .bsrUpdate(bsrUpdate)
  );

  tapsel_data #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_data (
    .tck(tck), .trstN(trstN), .drCtl(drCtl), .tdi(tdi),
    .userCode(userCode), .bsrTdo(bsrTdo), .tdo(tdo), .tdoEn(tdoEn)
  );
endmodule

// File: tb/tapsel_top_tb.sv
module tapsel_top_tb;
  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tlResetSt = 0, capIrSt = 0, shiftIrSt = 0, updIrSt = 0;
  logic capDrSt = 0, shiftDrSt = 0, updDrSt = 0, tdi = 0, bsrTdo = 0;
  logic [31:0] userCode = 32'hC0DE_5A17;
  logic tdo, tdoEn, pinFromBsr, coreFromBsr, pinHighZ;
  logic bsrCapture, bsrShift, bsrUpdate;

  int checks = 0;
  int errors = 0;
  logic [3:0] refOp;
  localparam logic [31:0] EXP_ID = {4'h3, 16'hA5C1, 11'h2B5, 1'b1};

  always #10 tck = ~tck;

  tapsel_top u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference decode: pin word {pinFromBsr, coreFromBsr, pinHighZ}
  function automatic logic [2:0] refPins(input logic [3:0] op);
    case (op)
      4'b0000: return 3'b100;
      4'b0100: return 3'b010;
      4'b0101: return 3'b100;
      4'b0110: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction
  // 0 bypass, 1 identification, 2 boundary
  function automatic int refPath(input logic [3:0] op);
    if (op == 4'b0000 || op == 4'b0001 || op == 4'b0100) return 2;
    if (op == 4'b0010 || op == 4'b0011) return 1;
    return 0;
  endfunction

  task automatic tick();
    @(posedge tck); #1;
  endtask

  task automatic scanIr(input logic [3:0] op, input string req);
    logic [3:0] seen;
    capIrSt = 1; tick(); capIrSt = 0;
    shiftIrSt = 1;
    for (int i = 0; i < 4; i++) begin
      tdi = op[i];
      @(negedge tck); #1;
      seen[i] = tdo;
      if (i == 0) chk("R12 tdoEn in Shift-IR", tdoEn, 1);
      tick();
    end
    shiftIrSt = 0;
    chk("R1 IR capture pattern", seen, 4'b0001);
    @(negedge tck); #1;
    chk("R2 pins unchanged before Update-IR",
        {pinFromBsr, coreFromBsr, pinHighZ}, refPins(refOp));
    tick();
    updIrSt = 1; tick(); updIrSt = 0;
    refOp = op;
    @(negedge tck); #1;
    chk({req, " pin controls"}, {pinFromBsr, coreFromBsr, pinHighZ}, refPins(op));
    chk("R12 tdoEn low when idle", tdoEn, 0);
    tick();
  endtask

  task automatic scanDr(input int n, input logic [63:0] din, input string req);
    logic [63:0] seen = '0;
    logic [63:0] exp  = '0;
    int p = refPath(refOp);
    capDrSt = 1;
    @(negedge tck); #1;
    chk("R11 capture strobe", bsrCapture, p == 2);
    tick(); capDrSt = 0;
    shiftDrSt = 1;
    for (int i = 0; i < n; i++) begin
      tdi = din[i];
      bsrTdo = ~din[i];
      @(negedge tck); #1;
      seen[i] = tdo;
      if (i == 0) chk("R11 shift strobe", bsrShift, p == 2);
      tick();
    end
    shiftDrSt = 0;
    updDrSt = 1;
    @(negedge tck); #1;
    chk("R11 update strobe", bsrUpdate, p == 2);
    tick(); updDrSt = 0;
    if (p == 2) exp = ~din;
    else if (p == 1) exp = {32'h0, (refOp == 4'b0011) ? userCode : EXP_ID};
    else exp = {din[62:0], 1'b0};
    for (int i = n; i < 64; i++) exp[i] = 1'b0;
    chk({req, " serial data"}, seen, exp);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    refOp = 4'b0010;
    repeat (3) @(posedge tck);
    #1;
    chk("R13 reset pins", {pinFromBsr, coreFromBsr, pinHighZ, tdoEn}, 4'b0000);
    trstN = 1;
    tick();
    scanDr(32, 64'h0, "R2 R4 IDCODE after reset");
    scanIr(4'b1111, "R3 BYPASS");
    scanDr(16, 64'hB4E1, "R3 bypass delay");
    scanIr(4'b0000, "R6 EXTEST");
    scanDr(12, 64'h9C3, "R6 boundary path");
    scanIr(4'b0001, "R8 SAMPLE");
    scanDr(10, 64'h2A7, "R8 boundary path");
    scanIr(4'b0100, "R7 INTEST");
    scanDr(9, 64'h15B, "R7 boundary path");
    scanIr(4'b0011, "R5 USERCODE");
    scanDr(32, 64'hFFFF_0000, "R5 user code");
    userCode = 32'h1234_8765;
    scanDr(32, 64'h0, "R5 user code refresh");
    scanIr(4'b0101, "R9 CLAMP");
    scanDr(8, 64'h6D, "R9 bypass path");
    scanIr(4'b0110, "R10 HIGHZ");
    scanDr(8, 64'hA3, "R10 bypass path");
    scanIr(4'b1001, "R3 unassigned code");
    scanDr(8, 64'h5C, "R3 unassigned bypass");
    scanIr(4'b0010, "R4 IDCODE");
    scanDr(32, 64'hFFFF_FFFF, "R4 identification");
    scanIr(4'b0000, "R2 EXTEST before TLR");
    tlResetSt = 1; tick(); tlResetSt = 0;
    refOp = 4'b0010;
    @(negedge tck); #1;
    chk("R2 Test-Logic-Reset pins", {pinFromBsr, coreFromBsr, pinHighZ}, 3'b000);
    tick();
    scanDr(32, 64'h0, "R2 IDCODE after TLR");
    scanIr(4'b0000, "R13 EXTEST before trst");
    #4;
    trstN = 0;
    #2;
    chk("R13 async reset clears pins", {pinFromBsr, tdoEn}, 2'b00);
    tick();
    trstN = 1;
    tick();
    refOp = 4'b0010;
    scanDr(32, 64'h0, "R13 IDCODE after trst");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule